// File: doc/BRIEF.md
# DPLL Lock Qualification Controller

This block brings a digital PLL up to a stable lock at start-up. When `start_i` is taken, it reads a host-clock measurement word and sorts the host clock into one of four frequency bands. From that band it derives a tuning window, a low bound and a high bound. It writes the window to the PLL with the tuning-enable bit set. It then polls the PLL's lock flag at a fixed interval.

Lock is only accepted after the flag stays set on a long run of consecutive clock cycles, counted from the first poll that saw it set. A single clear sample during that run ends the attempt at once. A failed attempt rewrites the window with tuning-enable clear and starts a new attempt. There is a limit on the number of attempts; when it is reached, the block reports a fatal failure. On success, the block writes the window back with tuning-enable clear and every other bit unchanged.

The PLL is outside the block. Its window register is `win_reg_o`, which is loaded whenever `win_wr_o` pulses, and its lock flag is `pll_lock_i`.

Top module: `dpll_lock_ctrl`

## Requirements
- R1: After reset, `win_reg_o` is zero and `win_wr_o`, `done_o`, `locked_o` and `failed_o` are all low.
- R2: The host frequency is `cnt*77/192` (integer division), where `cnt` is measurement bits 8:0. It is banded to 33 MHz if below 40, 40 MHz if below 45, 50 MHz if below 55, and 66 MHz otherwise. If measurement bits 31:12 are not 0xABCDE, the band is 33 MHz.
- R3: On the edge where `start_i` is taken in idle, the block writes the window, pulsing `win_wr_o` for one cycle. The window layout is: `lo = band*48/66` in bits 7:0, `lo+2` in bits 31:16, bit 8 (tuning-enable) set, and every other bit zero.
- R4: After each window write, the lock flag is polled once every POLL_CYCLES cycles. The first poll falls POLL_CYCLES edges after the write edge. An attempt fails once SEEK_POLLS polls in a row have seen the flag clear.
- R5: After a poll sees the flag set, the flag is sampled on each of the next HOLD_SAMPLES edges. If all of those samples are set, the block writes the window with bit 8 cleared, and `done_o` and `locked_o` pulse on that same edge. For a first-attempt lock at poll n, that edge is n*POLL_CYCLES+HOLD_SAMPLES edges after the start edge.
- R6: A single clear sample during the hold run fails the attempt on that edge.
- R7: Every failed attempt rewrites the window with bit 8 cleared and the frequency fields unchanged. Unless the attempt limit has been reached, a new attempt starts, with its first poll POLL_CYCLES edges later.
- R8: When MAX_TRIES attempts have failed, `failed_o` and `done_o` pulse on the edge of the last rewrite. No further writes follow, and the block returns to idle.
- R9: `start_i` is ignored while an attempt sequence is running.
- R10: `done_o`, `locked_o` and `failed_o` are single-cycle pulses. `locked_o` and `failed_o` are never high together, and each comes with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a lock sequence (taken only when idle) |
| meas_word_i | input | 32 | Host-clock measurement: signature in 31:12, count in 8:0 |
| pll_lock_i | input | 1 | Lock flag from the PLL |
| win_reg_o | output | 32 | Window register value for the PLL |
| win_wr_o | output | 1 | One-cycle strobe loading `win_reg_o` into the PLL |
| done_o | output | 1 | Sequence finished (pulse) |
| locked_o | output | 1 | Sequence finished with a qualified lock (pulse) |
| failed_o | output | 1 | All attempts failed (pulse) |

## Verification
The bench targets band edges on both sides (counts 99/100, 112/113, 137/138), a bad signature, and a single-cycle dropout in the middle of the hold run. A design that checked only the final sample would report lock after the dropout instead of adding a third window write. Exact edge counts from start to `done_o` expose poll-interval or hold-length errors of one cycle. The all-fail case makes sure exactly nine writes occur and that the block goes silent after the last one. A start pulse during a run must leave the write log and the latency unchanged; a design that restarts would show an extra write with tuning set.

// File: rtl/dpll_lock_pkg.sv
package dpll_lock_pkg;

  localparam logic [19:0] MEAS_SIG   = 20'hABCDE;
  localparam int          TUNE_BIT   = 8;
  localparam int          HIGH_LSB   = 16;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_SEEK,
    LK_HOLD
  } lk_state_t;

  // Host clock band in MHz from a measurement word (R2)
  function automatic logic [6:0] band_mhz(input logic [31:0] w);
    logic [16:0] f;
    if (w[31:12] != MEAS_SIG) return 7'd33;
    f = (17'(w[8:0]) * 17'd77) / 17'd192;
    if (f < 17'd40) return 7'd33;
    if (f < 17'd45) return 7'd40;
    if (f < 17'd55) return 7'd50;
    return 7'd66;
  endfunction

  // Low window bound for a 66 MHz PLL target (R3)
  function automatic logic [7:0] win_low(input logic [6:0] mhz);
    logic [12:0] p;
    p = 13'(mhz) * 13'd48;
    return 8'(p / 13'd66);
  endfunction

endpackage

// File: rtl/dpll_freq_band.sv
module dpll_freq_band
  import dpll_lock_pkg::*;
(
  input  logic [31:0] meas_word_i,
  output logic [7:0]  f_low_o,
  output logic [15:0] f_high_o
);
  logic [6:0] mhz;

  always_comb begin
    mhz      = band_mhz(meas_word_i);
    f_low_o  = win_low(mhz);
    f_high_o = 16'(f_low_o) + 16'd2;
  end
endmodule

// File: rtl/dpll_poll_timer.sv
module dpll_poll_timer #(
  parameter int POLL_CYCLES = 3300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(POLL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: poll counter never passes its interval
  a_r4_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  generate
    if (POLL_CYCLES > 1) begin : g_spacing
      // R4: polls are at least two cycles apart when the interval allows it
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dpll_step_counter.sv
module dpll_step_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // R4/R5/R8: no count (polls, hold samples, attempts) runs past its limit
  a_r8_count_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/dpll_lock_ctrl.sv
module dpll_lock_ctrl
  import dpll_lock_pkg::*;
#(
  parameter int POLL_CYCLES  = 3300,
  parameter int SEEK_POLLS   = 20480,
  parameter int HOLD_SAMPLES = 4096,
  parameter int MAX_TRIES    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] meas_word_i,
  input  logic        pll_lock_i,
  output logic [31:0] win_reg_o,
  output logic        win_wr_o,
  output logic        done_o,
  output logic        locked_o,
  output logic        failed_o
);
  localparam logic [31:0] TUNE_MASK = 32'd1 << TUNE_BIT;

  lk_state_t   st_q;
  logic [7:0]  f_low;
  logic [15:0] f_high;

  // named internal events
  logic take_start, poll_tick, lock_seen, seek_miss, seek_exhaust;
  logic hold_drop, hold_pass, attempt_fail;
  logic seek_last, hold_last, try_last;
  logic seek_clr, hold_clr, hold_inc, try_inc;

  dpll_freq_band u_band (
    .meas_word_i (meas_word_i),
    .f_low_o     (f_low),
    .f_high_o    (f_high)
  );

  dpll_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == LK_SEEK),
    .tick_o (poll_tick)
  );

  assign take_start   = (st_q == LK_IDLE) && start_i;
  assign lock_seen    = poll_tick && pll_lock_i;
  assign seek_miss    = poll_tick && !pll_lock_i;
  assign seek_exhaust = seek_miss && seek_last;
  assign hold_drop    = (st_q == LK_HOLD) && !pll_lock_i;
  assign hold_pass    = (st_q == LK_HOLD) && pll_lock_i && hold_last;
  assign attempt_fail = seek_exhaust || hold_drop;

  assign seek_clr = take_start || attempt_fail || lock_seen;
  assign hold_clr = (st_q != LK_HOLD) || hold_pass || hold_drop;
  assign hold_inc = (st_q == LK_HOLD) && pll_lock_i;
  assign try_inc  = attempt_fail && !try_last;

  dpll_step_counter #(.LIMIT(SEEK_POLLS)) u_seek_cnt (
    .clk (clk), .rst_n (rst_n), .clr_i (seek_clr), .inc_i (seek_miss), .last_o (seek_last)
  );

  dpll_step_counter #(.LIMIT(HOLD_SAMPLES)) u_hold_cnt (
    .clk (clk), .rst_n (rst_n), .clr_i (hold_clr), .inc_i (hold_inc), .last_o (hold_last)
  );

  dpll_step_counter #(.LIMIT(MAX_TRIES)) u_try_cnt (
    .clk (clk), .rst_n (rst_n), .clr_i (take_start), .inc_i (try_inc), .last_o (try_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LK_IDLE;
      win_reg_o <= '0;
      win_wr_o  <= 1'b0;
      done_o    <= 1'b0;
      locked_o  <= 1'b0;
      failed_o  <= 1'b0;
    end else begin
      win_wr_o <= 1'b0;
      done_o   <= 1'b0;
      locked_o <= 1'b0;
      failed_o <= 1'b0;
      unique case (st_q)
        LK_IDLE: begin
          if (take_start) begin
            win_reg_o <= (32'(f_high) << HIGH_LSB) | TUNE_MASK | 32'(f_low);
            win_wr_o  <= 1'b1;
            st_q      <= LK_SEEK;
          end
        end
        LK_SEEK: begin
          if (lock_seen) begin
            st_q <= LK_HOLD;
          end else if (seek_exhaust) begin
            win_reg_o <= win_reg_o & ~TUNE_MASK;
            win_wr_o  <= 1'b1;
            if (try_last) begin
              failed_o <= 1'b1;
              done_o   <= 1'b1;
              st_q     <= LK_IDLE;
            end
          end
        end
        LK_HOLD: begin
          if (hold_drop) begin
            win_reg_o <= win_reg_o & ~TUNE_MASK;
            win_wr_o  <= 1'b1;
            if (try_last) begin
              failed_o <= 1'b1;
              done_o   <= 1'b1;
              st_q     <= LK_IDLE;
            end else begin
              st_q <= LK_SEEK;
            end
          end else if (hold_pass) begin
            win_reg_o <= win_reg_o & ~TUNE_MASK;
            win_wr_o  <= 1'b1;
            locked_o  <= 1'b1;
            done_o    <= 1'b1;
            st_q      <= LK_IDLE;
          end
        end
        default: st_q <= LK_IDLE;
      endcase
    end
  end

  // R3: a taken start writes the window with tuning enabled
  a_r3_first_write_tunes: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> (win_wr_o && win_reg_o[TUNE_BIT]));

  // R5: a qualified lock comes with a write that drops tuning-enable
  a_r5_lock_clears_tune: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (win_wr_o && !win_reg_o[TUNE_BIT]));

  // R6: one clear sample in the hold run fails the attempt
  a_r6_drop_rewrites: assert property (@(posedge clk) disable iff (!rst_n)
    hold_drop |=> (win_wr_o && !win_reg_o[TUNE_BIT] && !locked_o));

  // R9: a start while busy never causes a tuning write
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != LK_IDLE) && start_i) |=> !(win_wr_o && win_reg_o[TUNE_BIT]));

  // R10: outcomes are exclusive and each carries done
  a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_o && failed_o));

  a_r10_outcome_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o || failed_o) |-> done_o);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/dpll_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module dpll_lock_ctrl_tb_top;
  localparam int P = 3;
  localparam int S = 20;
  localparam int H = 16;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] meas_word_i = 32'h0;
  logic        pll_lock_i = 1'b0;
  logic [31:0] win_reg_o;
  logic        win_wr_o, done_o, locked_o, failed_o;

  always #2 clk = ~clk; // 250 MHz

  dpll_lock_ctrl #(.POLL_CYCLES(P), .SEEK_POLLS(S), .HOLD_SAMPLES(H), .MAX_TRIES(T)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .meas_word_i (meas_word_i),
    .pll_lock_i (pll_lock_i), .win_reg_o (win_reg_o), .win_wr_o (win_wr_o),
    .done_o (done_o), .locked_o (locked_o), .failed_o (failed_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // PLL model and output monitor
  int mcnt = 0, wr_seen = 0;
  int m_dead = 0, m_delay = 0, m_drop_tries = 0, m_drop_at = -1;
  int n_done = 0, n_lock = 0, n_fail = 0;
  logic [31:0] wlog [0:15];

  always @(negedge clk) begin
    if (win_wr_o) begin
      if (wr_seen < 16) wlog[wr_seen] = win_reg_o;
      wr_seen = wr_seen + 1;
      mcnt = 0;
    end else begin
      mcnt = mcnt + 1;
    end
    if (done_o)   n_done = n_done + 1;
    if (locked_o) n_lock = n_lock + 1;
    if (failed_o) n_fail = n_fail + 1;
    pll_lock_i = ((wr_seen - 1) >= m_dead) && (mcnt >= m_delay) &&
                 !(((wr_seen - 1) < m_drop_tries) && (mcnt == m_drop_at));
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_window(input logic [31:0] w);
    int f, mhz, lo;
    f = int'(w[8:0]) * 77 / 192;
    if (w[31:12] != 20'hABCDE) mhz = 33;
    else if (f >= 55) mhz = 66;
    else if (f >= 45) mhz = 50;
    else if (f >= 40) mhz = 40;
    else mhz = 33;
    lo = mhz * 48 / 66;
    return ((lo + 2) << 16) | 32'h100 | lo;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // one lock sequence; cyc = negedges from start edge to done seen
  task automatic run(input logic [31:0] w, input int dead, input int dly,
                     input int drops, input int drop_at, input bit poke, output int cyc);
    @(negedge clk); #1;
    wr_seen = 0; mcnt = 0; n_done = 0; n_lock = 0; n_fail = 0;
    m_dead = dead; m_delay = dly; m_drop_tries = drops; m_drop_at = drop_at;
    meas_word_i = w;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 4) begin
        #1 start_i = 1'b1; meas_word_i = 32'hABCDE1FF;
        @(negedge clk); cyc++;
        #1 start_i = 1'b0;
      end
      if (done_o) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(win_reg_o == 32'h0, "R1 win_reg", win_reg_o, 0);
    chk({win_wr_o, done_o, locked_o, failed_o} == 4'b0, "R1 strobes",
        {win_wr_o, done_o, locked_o, failed_o}, 0);
  endtask

  task automatic t_bands();
    logic [31:0] words [0:8];
    int cyc, e;
    words[0] = 32'h12345064; // bad signature
    words[1] = 32'hABCDE063; // 99 -> 39
    words[2] = 32'hABCDE064; // 100 -> 40
    words[3] = 32'hABCDE070; // 112 -> 44
    words[4] = 32'hABCDE071; // 113 -> 45
    words[5] = 32'hABCDE089; // 137 -> 54
    words[6] = 32'hABCDE08A; // 138 -> 55
    words[7] = 32'hABCDE1FF; // 511 -> 204
    words[8] = 32'hABCDEE7D; // ignored bits 11:9 set, 125 -> 50
    for (int k = 0; k < 9; k++) begin
      run(words[k], 0, 0, 0, -1, 1'b0, cyc);
      e = exp_window(words[k]);
      chk(wlog[0] == e, "R2 R3 first window", wlog[0], e);
      chk(wlog[1] == (e & ~32'h100), "R5 final window", wlog[1], e & ~32'h100);
      chk(n_lock == 1 && n_fail == 0 && n_done == 1, "R10 pulses", {n_done, n_lock, n_fail}, 1);
    end
    chk(exp_window(32'hABCDE1FF) == 32'h00320130, "R3 layout 66", exp_window(32'hABCDE1FF), 32'h00320130);
  endtask

  task automatic t_latency();
    int cyc;
    run(32'hABCDE07D, 0, 0, 0, -1, 1'b0, cyc);
    chk(cyc == P + H + 1, "R5 latency first poll", cyc, P + H + 1);
    run(32'hABCDE07D, 0, 7, 0, -1, 1'b0, cyc);
    chk(cyc == 3 * P + H + 1, "R4 latency third poll", cyc, 3 * P + H + 1);
    chk(wr_seen == 2, "R4 writes", wr_seen, 2);
  endtask

  task automatic t_dropout();
    int cyc, e;
    e = exp_window(32'hABCDE07D);
    run(32'hABCDE07D, 0, 0, 1, P + 5, 1'b0, cyc);
    chk(cyc == 29, "R6 dropout latency", cyc, 29);
    chk(wr_seen == 3, "R6 extra write", wr_seen, 3);
    chk(wlog[1] == (e & ~32'h100), "R7 rewrite value", wlog[1], e & ~32'h100);
    chk(n_lock == 1 && n_fail == 0, "R7 retry locks", n_lock, 1);
  endtask

  task automatic t_seek_exhaust();
    int cyc, e;
    e = exp_window(32'hABCDE089);
    run(32'hABCDE089, 2, 0, 0, -1, 1'b0, cyc);
    chk(cyc == 2 * S * P + P + H + 1, "R4 seek limit latency", cyc, 2 * S * P + P + H + 1);
    chk(wr_seen == 4, "R7 write count", wr_seen, 4);
    chk(wlog[2] == (e & ~32'h100), "R7 second rewrite", wlog[2], e & ~32'h100);
    chk(n_lock == 1, "R7 third attempt locks", n_lock, 1);
  endtask

  task automatic t_all_fail();
    int cyc;
    run(32'hABCDE064, T, 0, 0, -1, 1'b0, cyc);
    chk(cyc == T * S * P + 1, "R8 give-up latency", cyc, T * S * P + 1);
    chk(n_fail == 1 && n_lock == 0 && n_done == 1, "R8 failed pulse", {n_done, n_lock, n_fail}, 32'h00010001);
    chk(wr_seen == T + 1, "R8 writes", wr_seen, T + 1);
    repeat (40) @(negedge clk);
    chk(wr_seen == T + 1, "R8 silent after", wr_seen, T + 1);
    chk(n_done == 1, "R10 single done", n_done, 1);
  endtask

  task automatic t_busy_start();
    int cyc, e;
    e = exp_window(32'hABCDE071);
    run(32'hABCDE071, 0, 7, 0, -1, 1'b1, cyc);
    chk(cyc == 3 * P + H + 1, "R9 latency unchanged", cyc, 3 * P + H + 1);
    chk(wr_seen == 2, "R9 no restart write", wr_seen, 2);
    chk(wlog[1] == (e & ~32'h100), "R9 window kept", wlog[1], e & ~32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bands();
    t_latency();
    t_dropout();
    t_seek_exhaust();
    t_all_fail();
    t_busy_start();
    finish_run();
  end
endmodule